// File: doc/BRIEF.md
# Per-Bank Row State Tracker

This block sits inside a DRAM controller and keeps a live picture of which of the four banks have a row open, and which row that is. It consumes the command stream the controller is about to issue, one decoded command per clock, together with the bank select, the row address, an auto-precharge qualifier, an all-banks qualifier for precharge and the currently programmed burst-length code. From that it maintains an open flag and a stored row per bank.

The scheduler uses the outputs to decide what to issue next. A row-hit output compares the presented bank and row against the stored state. An illegal-command flag reports commands that break the open/closed rules; such commands never change the tracked state. An all-idle output qualifies mode-register loads. A read or write carrying auto precharge closes its bank by itself once the burst has finished, and a burst timer keeps the all-idle output low for as long as any data burst is still moving.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset every bank is closed, every stored row is zero, `illegal_o` is 0 and `all_idle_o` is 1.
- R2: An ACTIVE (`cmd_i`=1) to a closed bank opens that bank and stores `row_i` as its row, visible after the next rising clock edge.
- R3: An ACTIVE to a bank that is already open sets `illegal_o` and changes neither the open flags nor any stored row.
- R4: A READ (`cmd_i`=2) or WRITE (`cmd_i`=3) to a closed bank, or to a bank whose auto precharge is still pending, sets `illegal_o`, starts no burst and leaves every bank's state unchanged.
- R5: `row_hit_o` is 1, in the same cycle and without a clock edge, exactly when the bank selected by `bank_i` is open and its stored row equals `row_i`.
- R6: A PRECHARGE (`cmd_i`=4) with `pre_all_i`=0 closes only the selected bank; to a closed bank it is legal and has no effect.
- R7: A PRECHARGE with `pre_all_i`=1 closes every bank at the next clock edge, whatever `bank_i` holds.
- R8: A legal READ or WRITE with `auto_pre_i`=1 keeps its bank open for L clocks after the command edge and closes it at edge n+L, where L is half the burst length: `burst_len_i` code 1 gives 2 beats (L=1), code 2 gives 4 beats (L=2), code 3 gives 8 beats (L=4), and code 0 is treated as 2 beats.
- R9: `all_idle_o` is 1 exactly when no bank is open and no burst is in flight; a legal READ or WRITE at edge n keeps a burst in flight until edge n+L.
- R10: A mode-register load (`cmd_i`=5) while `all_idle_o` is 0 sets `illegal_o`; in no case does it change bank state.
- R11: `illegal_o` is registered: it reflects the command of the previous clock only, so a NOP (`cmd_i`=0) clears it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 mode-register load |
| bank_i | input | 2 | Bank select |
| row_i | input | 13 | Row address for ACTIVE and row-hit query |
| auto_pre_i | input | 1 | Auto precharge on READ/WRITE |
| pre_all_i | input | 1 | PRECHARGE applies to all banks |
| burst_len_i | input | 2 | Programmed burst-length code |
| bank_open_o | output | 4 | Open flag per bank, bit b for bank b |
| open_row_o | output | 52 | Stored row per bank, bank b at bits [13b+12:13b] |
| row_hit_o | output | 1 | Selected bank open with matching row |
| illegal_o | output | 1 | Previous command broke the bank rules |
| all_idle_o | output | 1 | No bank open and no burst in flight |

## Verification
The hardest state to reach is a bank that is still open but has a self-timed close pending, since it only exists for a few clocks after a read or write with auto precharge. The bench opens a bank, issues a write with auto precharge at the longest burst, and then within that window aims a read at the same bank and samples the open flag on every clock until the close edge, so both the rejection of the second access and the exact close cycle are seen at the ports.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_MRS = 3'd5
  } cmd_e;
endpackage

// File: rtl/bank_slot.sv
module bank_slot #(
  parameter int unsigned ROW_W = 13,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             ap_load_i,
  input  logic [CNT_W-1:0] ap_clks_i,
  input  logic             close_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ap_pend_o
);
  logic [CNT_W-1:0] ap_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o   <= 1'b0;
      row_o    <= '0;
      ap_cnt_q <= '0;
    end else if (close_i) begin
      open_o   <= 1'b0;
      ap_cnt_q <= '0;
    end else begin
      if (act_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
      end
      if (ap_load_i) begin
        ap_cnt_q <= ap_clks_i;
      end else if (ap_cnt_q != '0) begin
        ap_cnt_q <= ap_cnt_q - 1'b1;
        // self-timed close on the last burst clock
        if (ap_cnt_q == CNT_W'(1)) open_o <= 1'b0;
      end
    end
  end

  assign ap_pend_o = (ap_cnt_q != '0);
endmodule

// File: rtl/burst_timer.sv
module burst_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] clks_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= clks_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import bank_trk_pkg::*;
#(
  parameter int unsigned NBANK    = 4,
  parameter int unsigned ROW_W    = 13,
  parameter int unsigned MAX_CLKS = 4,
  localparam int unsigned BANK_W  = $clog2(NBANK),
  localparam int unsigned CNT_W   = $clog2(MAX_CLKS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             cmd_i,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic [ROW_W-1:0]       row_i,
  input  logic                   auto_pre_i,
  input  logic                   pre_all_i,
  input  logic [1:0]             burst_len_i,
  output logic [NBANK-1:0]       bank_open_o,
  output logic [NBANK*ROW_W-1:0] open_row_o,
  output logic                   row_hit_o,
  output logic                   illegal_o,
  output logic                   all_idle_o
);
  cmd_e cmd;
  logic [NBANK-1:0] ap_pend;
  logic [ROW_W-1:0] rows [NBANK];
  logic [CNT_W-1:0] burst_clks;
  logic is_act, is_rw, is_pre, is_mrs;
  logic sel_open, sel_pend;
  logic bad_act, bad_rw, bad_mrs, go_rw;
  logic busy;

  assign cmd    = cmd_e'(cmd_i);
  assign is_act = (cmd == CMD_ACT);
  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_pre = (cmd == CMD_PRE);
  assign is_mrs = (cmd == CMD_MRS);

  assign sel_open = bank_open_o[bank_i];
  assign sel_pend = ap_pend[bank_i];

  // two beats per clock
  always_comb begin
    case (burst_len_i)
      2'd2:    burst_clks = CNT_W'(2);
      2'd3:    burst_clks = CNT_W'(4);
      default: burst_clks = CNT_W'(1);
    endcase
  end

  assign bad_act = is_act & sel_open;
  assign bad_rw  = is_rw & (~sel_open | sel_pend);
  assign bad_mrs = is_mrs & ~all_idle_o;
  assign go_rw   = is_rw & ~bad_rw;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_b;
    assign hit_b = (bank_i == BANK_W'(b));
    bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (is_act & ~sel_open & hit_b),
      .row_i     (row_i),
      .ap_load_i (go_rw & auto_pre_i & hit_b),
      .ap_clks_i (burst_clks),
      .close_i   (is_pre & (pre_all_i | hit_b)),
      .open_o    (bank_open_o[b]),
      .row_o     (rows[b]),
      .ap_pend_o (ap_pend[b])
    );
    assign open_row_o[b*ROW_W +: ROW_W] = rows[b];
  end

  burst_timer #(.CNT_W(CNT_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go_rw),
    .clks_i (burst_clks),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_o <= 1'b0;
    else         illegal_o <= bad_act | bad_rw | bad_mrs;
  end

  assign all_idle_o = ~|bank_open_o & ~busy;
  assign row_hit_o  = sel_open & (rows[bank_i] == row_i);
endmodule

// File: rtl/bank_row_tracker_chk.sv
module bank_row_tracker_chk #(
  parameter int unsigned NBANK = 4,
  parameter int unsigned ROW_W = 13,
  localparam int unsigned BANK_W = $clog2(NBANK)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [2:0]             cmd_i,
  input logic [BANK_W-1:0]      bank_i,
  input logic                   pre_all_i,
  input logic [NBANK-1:0]       bank_open_o,
  input logic [NBANK*ROW_W-1:0] open_row_o,
  input logic                   illegal_o,
  input logic                   all_idle_o
);
  // R2
  act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && !bank_open_o[bank_i]) |=> bank_open_o[$past(bank_i)]);

  // R3
  bad_act_keeps_rows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && bank_open_o[bank_i]) |=> (illegal_o && $stable(open_row_o)));

  // R4
  rw_closed_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == 3'd2 || cmd_i == 3'd3) && !bank_open_o[bank_i]) |=> illegal_o);

  // R7
  pre_all_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4 && pre_all_i) |=> (bank_open_o == '0));

  // R9
  idle_means_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_idle_o |-> (bank_open_o == '0));

  // R10
  mrs_busy_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd5 && !all_idle_o) |=> illegal_o);

  // R11
  nop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0) |=> !illegal_o);
endmodule

bind bank_row_tracker bank_row_tracker_chk #(.NBANK(NBANK), .ROW_W(ROW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_i),
  .bank_i      (bank_i),
  .pre_all_i   (pre_all_i),
  .bank_open_o (bank_open_o),
  .open_row_o  (open_row_o),
  .illegal_o   (illegal_o),
  .all_idle_o  (all_idle_o)
);

// File: tb/bank_row_tracker_tb.sv
module bank_row_tracker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic [1:0]  bank_i = '0;
  logic [12:0] row_i = '0;
  logic        auto_pre_i = 1'b0;
  logic        pre_all_i = 1'b0;
  logic [1:0]  burst_len_i = 2'd2;
  logic [3:0]  bank_open_o;
  logic [51:0] open_row_o;
  logic        row_hit_o, illegal_o, all_idle_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  bank_row_tracker u_dut (.*);

  typedef struct packed {
    logic [2:0]  cmd;
    logic [1:0]  bank;
    logic [12:0] row;
    logic        ap;
    logic        pa;
    logic [3:0]  e_open;
    logic        e_ill;
    logic        e_idle;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 2'd0, 13'd5, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b0}, // R2 act b0
    '{3'd1, 2'd0, 13'd6, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b0}, // R3 act open b0
    '{3'd2, 2'd1, 13'd0, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b0}, // R4 read closed b1
    '{3'd1, 2'd2, 13'd9, 1'b0, 1'b0, 4'b0101, 1'b0, 1'b0}, // R2 act b2
    '{3'd2, 2'd0, 13'd0, 1'b0, 1'b0, 4'b0101, 1'b0, 1'b0}, // R9 read b0
    '{3'd0, 2'd0, 13'd0, 1'b0, 1'b0, 4'b0101, 1'b0, 1'b0}, // R11 nop
    '{3'd5, 2'd0, 13'd0, 1'b0, 1'b0, 4'b0101, 1'b1, 1'b0}, // R10 mrs busy
    '{3'd4, 2'd1, 13'd0, 1'b0, 1'b0, 4'b0101, 1'b0, 1'b0}, // R6 pre closed b1
    '{3'd4, 2'd0, 13'd0, 1'b0, 1'b0, 4'b0100, 1'b0, 1'b0}, // R6 pre b0
    '{3'd4, 2'd3, 13'd0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b1}, // R7 pre all
    '{3'd5, 2'd0, 13'd0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1}, // R10 mrs idle
    '{3'd3, 2'd3, 13'd0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1}  // R4 write closed b3
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [12:0] r,
                       input logic ap, input logic pa, input logic [1:0] bl);
    @(negedge clk_i);
    cmd_i = c; bank_i = b; row_i = r; auto_pre_i = ap; pre_all_i = pa; burst_len_i = bl;
    @(posedge clk_i);
    #1;
    cmd_i = 3'd0; auto_pre_i = 1'b0; pre_all_i = 1'b0;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20;
    // R1 reset state
    chk("R1 open", 64'(bank_open_o), 64'h0);
    chk("R1 rows", 64'(open_row_o), 64'h0);
    chk("R1 ill", 64'(illegal_o), 64'h0);
    chk("R1 idle", 64'(all_idle_o), 64'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].cmd, VECS[i].bank, VECS[i].row, VECS[i].ap, VECS[i].pa, 2'd2);
      chk($sformatf("R2-table%0d open", i), 64'(bank_open_o), 64'(VECS[i].e_open));
      chk($sformatf("R11 table%0d ill", i), 64'(illegal_o), 64'(VECS[i].e_ill));
      chk($sformatf("R9 table%0d idle", i), 64'(all_idle_o), 64'(VECS[i].e_idle));
    end
    // R3 rows kept after the rejected ACTIVE
    chk("R3 row b0", 64'(open_row_o[12:0]), 64'd5);
    chk("R2 row b2", 64'(open_row_o[38:26]), 64'd9);

    // R5 row hit
    issue(3'd1, 2'd1, 13'd300, 1'b0, 1'b0, 2'd2);
    @(negedge clk_i);
    bank_i = 2'd1; row_i = 13'd300; #1;
    chk("R5 hit", 64'(row_hit_o), 64'h1);
    row_i = 13'd301; #1;
    chk("R5 miss row", 64'(row_hit_o), 64'h0);
    bank_i = 2'd0; row_i = 13'd5; #1;
    chk("R5 closed bank", 64'(row_hit_o), 64'h0);

    // R8 auto precharge BL8: open for 4 clocks after command edge
    issue(3'd3, 2'd1, 13'd0, 1'b1, 1'b0, 2'd3);
    chk("R8 after n", 64'(bank_open_o[1]), 64'h1);
    chk("R9 busy", 64'(all_idle_o), 64'h0);
    // R4 read to bank with pending auto precharge
    issue(3'd2, 2'd1, 13'd0, 1'b0, 1'b0, 2'd3);
    chk("R4 pend ill", 64'(illegal_o), 64'h1);
    chk("R8 after n+1", 64'(bank_open_o[1]), 64'h1);
    issue(3'd0, 2'd0, 13'd0, 1'b0, 1'b0, 2'd3);
    chk("R8 after n+2", 64'(bank_open_o[1]), 64'h1);
    issue(3'd0, 2'd0, 13'd0, 1'b0, 1'b0, 2'd3);
    chk("R8 after n+3", 64'(bank_open_o[1]), 64'h1);
    issue(3'd0, 2'd0, 13'd0, 1'b0, 1'b0, 2'd3);
    chk("R8 after n+4", 64'(bank_open_o[1]), 64'h0);
    chk("R9 idle after ap", 64'(all_idle_o), 64'h1);
    chk("R8 row kept", 64'(open_row_o[25:13]), 64'd300);

    // R8 code 0 treated as 2 beats: closes after one clock
    issue(3'd1, 2'd2, 13'd77, 1'b0, 1'b0, 2'd0);
    issue(3'd2, 2'd2, 13'd0, 1'b1, 1'b0, 2'd0);
    chk("R8 code0 n", 64'(bank_open_o[2]), 64'h1);
    issue(3'd0, 2'd0, 13'd0, 1'b0, 1'b0, 2'd0);
    chk("R8 code0 n+1", 64'(bank_open_o[2]), 64'h0);

    // R9 burst without auto precharge after all banks closed
    issue(3'd1, 2'd3, 13'd1, 1'b0, 1'b0, 2'd2);
    issue(3'd3, 2'd3, 13'd0, 1'b0, 1'b0, 2'd2);
    issue(3'd4, 2'd0, 13'd0, 1'b0, 1'b1, 2'd2);
    chk("R9 burst holds idle low", 64'(all_idle_o), 64'h0);
    issue(3'd0, 2'd0, 13'd0, 1'b0, 1'b0, 2'd2);
    chk("R9 idle after burst", 64'(all_idle_o), 64'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule